// File: doc/BRIEF.md
# Pipelined SIMD Dot-Product Reducer

This block takes a pair of wide operand words, each split into equal signed lanes, and reduces them to a single scalar every clock. In its arithmetic mode, it multiplies corresponding lanes of the two words and adds the products together through a registered binary adder tree. Each per-beat sum can also be folded into a running accumulator, so a long dot product can be streamed through the block one beat at a time. Two logic modes skip the multipliers and combine the lanes of the first operand with a bitwise AND or a bitwise OR through the same tree.

All three modes take the same fixed number of cycles, so results always leave in the order the beats came in, and a new beat is accepted on every clock. A clear request zeroes the accumulator's starting point for the next arithmetic beat. With default parameters there are eight 16-bit lanes in each 128-bit operand, products are 32 bits, per-beat sums are 35 bits, and the accumulator is 44 bits.

Top module: `simd_dot_reducer`

## Requirements
- R1: With `in_op` = 2'b00 (dot), `out_scalar` equals the sum over lanes k of a_k*b_k. Lane k occupies bits [16k+15:16k] of each operand and is two's complement. The sum is a 35-bit two's-complement value.
- R2: A beat sampled with `in_valid` high at clock edge e produces exactly one `out_valid` pulse, visible after edge e+6 (seven edges counting e). Results come out in input order, whatever their opcode.
- R3: Beats may arrive on consecutive cycles with no gaps, and every one of them produces its own correct result.
- R4: A dot beat adds its sign-extended `out_scalar` into the accumulator. `out_acc` shows the updated total in the same cycle as that beat's `out_valid`.
- R5: An `in_clear` pulse, sampled with or without `in_valid`, makes the next dot beat at or after it start from zero, so `out_acc` for that beat equals its own scalar.
- R6: With `in_op` = 2'b01, `out_scalar` is the bitwise AND of all lanes of `in_vec_a`, zero-extended, and `in_vec_b` has no effect.
- R7: With `in_op` = 2'b10, `out_scalar` is the bitwise OR of all lanes of `in_vec_a`, zero-extended, and `in_vec_b` has no effect.
- R8: AND and OR beats leave `out_acc` unchanged and do not use up a pending clear.
- R9: During and right after reset, `out_valid`, `out_scalar` and `out_acc` are all zero.
- R10: 256 consecutive dot beats with every lane at -32768 in both operands accumulate to exactly 2^41 with no wrap. Each of those beats has a scalar of 2^33.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Beat present on the operand inputs |
| in_op | input | 2 | 00 dot, 01 AND of A lanes, 10 OR of A lanes, 11 treated as dot |
| in_clear | input | 1 | Restart accumulation at the next dot beat |
| in_vec_a | input | 128 | First operand, eight 16-bit lanes |
| in_vec_b | input | 128 | Second operand, eight 16-bit lanes |
| out_valid | output | 1 | One-cycle pulse per finished beat |
| out_scalar | output | 35 | Reduced value of the finished beat |
| out_acc | output | 44 | Running accumulator after the finished beat |

## Verification
Small ascending lane values give a hand-checkable dot sum, and mixed-sign lanes show whether the products are taken as signed. A run of random back-to-back beats exposes any stage that loses or reorders beats under full throughput. Logic beats are sent with the same first operand and different second operands, which shows whether B leaks into the AND/OR path. Logic beats are also placed between a clear and a dot beat, which shows whether they disturb the accumulator or the pending clear. A 256-beat run with every lane at the most negative value tells a full-width accumulator apart from one that wraps.

// File: rtl/dotred_pkg.sv
// Shared definitions for the dot-product reducer.
// Assumes a 2-bit opcode field on the block's input.
package dotred_pkg;

    typedef enum logic [1:0] {
        OP_DOT     = 2'b00,
        OP_AND     = 2'b01,
        OP_OR      = 2'b10,
        OP_DOT_ALT = 2'b11
    } red_op_e;

    // True for the opcodes that skip the multipliers.
    function automatic logic is_logic_op(input red_op_e op);
        return (op == OP_AND) || (op == OP_OR);
    endfunction

endpackage

// File: rtl/dotred_lane_mul.sv
// One lane of the three-stage multiply pipeline.
// Stage 1 registers the operands. Stage 2 forms the signed product, or
// forwards operand A zero-extended for the logic opcodes. Stage 3
// re-registers the result. op_s1 must line up with the stage-1 registers.
module dotred_lane_mul
    import dotred_pkg::*;
#(
    parameter int EL_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [EL_W-1:0]       a_in,
    input  logic [EL_W-1:0]       b_in,
    input  red_op_e               op_s1,
    output logic [2*EL_W-1:0]     prod_out
);
    localparam int PROD_W = 2 * EL_W;

    logic [EL_W-1:0]          a_s1_q;
    logic [EL_W-1:0]          b_s1_q;
    logic signed [PROD_W-1:0] a_ext;
    logic signed [PROD_W-1:0] b_ext;
    logic signed [PROD_W-1:0] mult;
    logic [PROD_W-1:0]        p_s2_q;
    logic [PROD_W-1:0]        p_s3_q;

    // Sign-extend the lane operands and multiply at product width.
    always_comb begin
        a_ext = {{EL_W{a_s1_q[EL_W-1]}}, a_s1_q};
        b_ext = {{EL_W{b_s1_q[EL_W-1]}}, b_s1_q};
        mult  = a_ext * b_ext;
    end

    // Stage 1: capture the lane operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_s1_q <= '0;
            b_s1_q <= '0;
        end else begin
            a_s1_q <= a_in;
            b_s1_q <= b_in;
        end
    end

    // Stages 2 and 3: product or bypass, then the final product register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_s2_q <= '0;
            p_s3_q <= '0;
        end else begin
            p_s2_q <= is_logic_op(op_s1) ? {{EL_W{1'b0}}, a_s1_q} : mult;
            p_s3_q <= p_s2_q;
        end
    end

    assign prod_out = p_s3_q;

endmodule

// File: rtl/dotred_tree.sv
// Registered binary reduction tree, stored as a heap.
// Node i has children 2i+1 and 2i+2, and the leaves sit after the inner
// nodes. Each inner node is a register, so the root lags the leaves by
// log2(LANES) cycles. Each depth carries the opcode of the beat it holds.
// Assumes LANES is a power of two, at least 2, and OUT_W > IN_W.
module dotred_tree
    import dotred_pkg::*;
#(
    parameter int LANES   = 8,
    parameter int IN_W    = 32,
    parameter int OUT_W   = 35,
    parameter int LOGIC_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  red_op_e                 op_in,
    input  logic [LANES*IN_W-1:0]   leaves,
    output logic [OUT_W-1:0]        sum_out,
    output red_op_e                 op_out
);
    localparam int LEVELS = $clog2(LANES);
    localparam int INNER  = LANES - 1;

    logic [OUT_W-1:0] leaf_ext [LANES];
    logic [OUT_W-1:0] inner_q  [INNER];
    red_op_e          depth_op_q [LEVELS];

    // Combining step chosen by opcode: add, AND or OR.
    function automatic logic [OUT_W-1:0] combine(input red_op_e op,
                                                 input logic [OUT_W-1:0] x,
                                                 input logic [OUT_W-1:0] y);
        case (op)
            OP_AND:  return x & y;
            OP_OR:   return x | y;
            default: return x + y;
        endcase
    endfunction

    // Sign-extend each leaf to tree width; bypassed lanes already have a zero top bit.
    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            leaf_ext[k] = {{(OUT_W-IN_W){leaves[k*IN_W+IN_W-1]}}, leaves[k*IN_W +: IN_W]};
        end
    end

    // Carry the opcode down the depths alongside its data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int d = 0; d < LEVELS; d++) depth_op_q[d] <= OP_DOT;
        end else begin
            depth_op_q[LEVELS-1] <= op_in;
            for (int d = 0; d < LEVELS-1; d++) depth_op_q[d] <= depth_op_q[d+1];
        end
    end

    for (genvar i = 0; i < INNER; i++) begin : g_node
        localparam int LC = 2*i + 1;
        localparam int RC = 2*i + 2;
        localparam int D  = $clog2(i + 2) - 1;
        logic [OUT_W-1:0] lval;
        logic [OUT_W-1:0] rval;
        red_op_e          node_op;

        if (LC >= INNER) begin : g_leafkids
            assign lval = leaf_ext[LC-INNER];
            assign rval = leaf_ext[RC-INNER];
        end else begin : g_innerkids
            assign lval = inner_q[LC];
            assign rval = inner_q[RC];
        end

        if (D + 1 == LEVELS) begin : g_op_in
            assign node_op = op_in;
        end else begin : g_op_depth
            assign node_op = depth_op_q[D+1];
        end

        // Register this node's combined value.
        always_ff @(posedge clk) begin
            if (!rst_n) inner_q[i] <= '0;
            else        inner_q[i] <= combine(node_op, lval, rval);
        end
    end

    assign sum_out = inner_q[0];
    assign op_out  = depth_op_q[0];

    // R6 R7: a logic reduction never sets bits above the lane width
    logic_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_logic_op(op_out) |-> (sum_out[OUT_W-1:LOGIC_W] == '0));

endmodule

// File: rtl/dotred_accum.sv
// Output stage: registers the per-beat scalar and keeps the running total.
// A clear request stays pending until a dot beat uses it. Logic beats
// pass through without touching the total or the pending clear.
// Assumes beat_* are aligned with the tree root.
module dotred_accum
    import dotred_pkg::*;
#(
    parameter int SUM_W = 35,
    parameter int ACC_W = 44
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat_valid,
    input  red_op_e          beat_op,
    input  logic             beat_clr,
    input  logic [SUM_W-1:0] beat_sum,
    output logic             out_valid,
    output logic [SUM_W-1:0] out_scalar,
    output logic [ACC_W-1:0] out_acc
);
    logic                    valid_q;
    red_op_e                 op_q;
    logic [SUM_W-1:0]        scalar_q;
    logic [ACC_W-1:0]        acc_q;
    logic                    clr_pend_q;
    logic                    cleared_q;
    logic                    clr_now;
    logic                    take_dot;
    logic signed [SUM_W-1:0] sum_s;
    logic signed [ACC_W-1:0] sum_ext;
    logic signed [SUM_W-1:0] scalar_s;
    logic signed [ACC_W-1:0] scalar_ext;

    // Merge the pending clear with the arriving one and sign-extend the sums.
    always_comb begin
        clr_now    = clr_pend_q | beat_clr;
        take_dot   = beat_valid && !is_logic_op(beat_op);
        sum_s      = beat_sum;
        sum_ext    = sum_s;
        scalar_s   = scalar_q;
        scalar_ext = scalar_s;
    end

    // Update the output registers, the accumulator and the pending clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q    <= 1'b0;
            op_q       <= OP_DOT;
            scalar_q   <= '0;
            acc_q      <= '0;
            clr_pend_q <= 1'b0;
            cleared_q  <= 1'b0;
        end else begin
            valid_q <= beat_valid;
            if (beat_valid) begin
                op_q     <= beat_op;
                scalar_q <= beat_sum;
            end
            if (take_dot) begin
                acc_q      <= (clr_now ? '0 : acc_q) + sum_ext;
                clr_pend_q <= 1'b0;
                cleared_q  <= clr_now;
            end else begin
                clr_pend_q <= clr_now;
                cleared_q  <= 1'b0;
            end
        end
    end

    assign out_valid  = valid_q;
    assign out_scalar = scalar_q;
    assign out_acc    = acc_q;

    // R8
    logic_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && is_logic_op(op_q)) |-> $stable(acc_q));

    // R5
    clear_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && cleared_q) |-> (acc_q == scalar_ext));

endmodule

// File: rtl/simd_dot_reducer.sv
// Top of the pipelined SIMD dot-product reducer.
// Splits the operands into lanes, runs one multiply pipe per lane, reduces
// the lanes in a registered tree and hands the root to the accumulator.
// A sideband shift register keeps valid, opcode and clear in step with the
// data. Total latency is MUL_LAT + log2(LANES) + 1 edges for every opcode.
module simd_dot_reducer
    import dotred_pkg::*;
#(
    parameter int LANES = 8,
    parameter int EL_W  = 16,
    parameter int ACC_W = 44
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                in_valid,
    input  logic [1:0]                          in_op,
    input  logic                                in_clear,
    input  logic [LANES*EL_W-1:0]               in_vec_a,
    input  logic [LANES*EL_W-1:0]               in_vec_b,
    output logic                                out_valid,
    output logic [2*EL_W+$clog2(LANES)-1:0]     out_scalar,
    output logic [ACC_W-1:0]                    out_acc
);
    localparam int PROD_W   = 2 * EL_W;
    localparam int LEVELS   = $clog2(LANES);
    localparam int SUM_W    = PROD_W + LEVELS;
    localparam int MUL_LAT  = 3;
    localparam int SB_D     = MUL_LAT + LEVELS;
    localparam int PIPE_LAT = SB_D + 1;
    localparam int CNT_W    = $clog2(PIPE_LAT + 2);

    logic                    sb_valid [SB_D];
    logic                    sb_clr   [SB_D];
    red_op_e                 sb_op    [SB_D];
    logic [LANES*PROD_W-1:0] prods;
    logic [SUM_W-1:0]        tree_sum;
    red_op_e                 tree_op;

    // Shift valid, opcode and clear along with the data stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SB_D; s++) begin
                sb_valid[s] <= 1'b0;
                sb_clr[s]   <= 1'b0;
                sb_op[s]    <= OP_DOT;
            end
        end else begin
            sb_valid[0] <= in_valid;
            sb_clr[0]   <= in_clear;
            sb_op[0]    <= red_op_e'(in_op);
            for (int s = 1; s < SB_D; s++) begin
                sb_valid[s] <= sb_valid[s-1];
                sb_clr[s]   <= sb_clr[s-1];
                sb_op[s]    <= sb_op[s-1];
            end
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        dotred_lane_mul #(.EL_W(EL_W)) lane_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .a_in     (in_vec_a[k*EL_W +: EL_W]),
            .b_in     (in_vec_b[k*EL_W +: EL_W]),
            .op_s1    (sb_op[0]),
            .prod_out (prods[k*PROD_W +: PROD_W])
        );
    end

    dotred_tree #(
        .LANES   (LANES),
        .IN_W    (PROD_W),
        .OUT_W   (SUM_W),
        .LOGIC_W (EL_W)
    ) tree_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_in   (sb_op[MUL_LAT-1]),
        .leaves  (prods),
        .sum_out (tree_sum),
        .op_out  (tree_op)
    );

    dotred_accum #(
        .SUM_W (SUM_W),
        .ACC_W (ACC_W)
    ) accum_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_valid (sb_valid[SB_D-1]),
        .beat_op    (sb_op[SB_D-1]),
        .beat_clr   (sb_clr[SB_D-1]),
        .beat_sum   (tree_sum),
        .out_valid  (out_valid),
        .out_scalar (out_scalar),
        .out_acc    (out_acc)
    );

    // Beats accepted but not yet delivered; used only by the checks below.
    logic [CNT_W-1:0] inflight_q;
    always_ff @(posedge clk) begin
        if (!rst_n) inflight_q <= '0;
        else        inflight_q <= inflight_q + CNT_W'(in_valid) - CNT_W'(out_valid);
    end

    // R2
    inflight_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inflight_q <= CNT_W'(PIPE_LAT));

    // R2
    no_orphan_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (inflight_q != '0));

    // R3: the opcode carried by the tree matches the sideband copy
    op_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sb_valid[SB_D-1] |-> (tree_op == sb_op[SB_D-1]));

endmodule

// File: tb/simd_dot_reducer_tb_top.sv
`timescale 1ns/1ps
module simd_dot_reducer_tb_top;
    localparam int LANES = 8;
    localparam int EL_W  = 16;
    localparam int VEC_W = LANES * EL_W;
    localparam int SUM_W = 35;
    localparam int ACC_W = 44;
    localparam int LAT   = 6;   // edges after the sampling edge

    typedef struct {
        logic [SUM_W-1:0] scalar;
        logic [ACC_W-1:0] acc;
        int               issue;
        string            req;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [1:0]       in_op = 2'b00;
    logic             in_clear = 1'b0;
    logic [VEC_W-1:0] in_vec_a = '0;
    logic [VEC_W-1:0] in_vec_b = '0;
    logic             out_valid;
    logic [SUM_W-1:0] out_scalar;
    logic [ACC_W-1:0] out_acc;

    int     n_checks = 0;
    int     n_fail   = 0;
    int     cyc      = 0;
    exp_t   expq[$];
    longint model_acc = 0;
    bit     model_pend = 1'b0;

    simd_dot_reducer dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_clear(in_clear), .in_vec_a(in_vec_a), .in_vec_b(in_vec_b),
        .out_valid(out_valid), .out_scalar(out_scalar), .out_acc(out_acc)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Scoreboard: every output beat is compared with the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R2", "unexpected out_valid", 1, 0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                chk(out_scalar == e.scalar, e.req, "scalar",
                    longint'($signed(out_scalar)), longint'($signed(e.scalar)));
                chk(out_acc == e.acc, e.req, "acc",
                    longint'($signed(out_acc)), longint'($signed(e.acc)));
                chk((cyc - e.issue) == LAT, "R2", "latency", cyc - e.issue, LAT);
            end
        end
    end

    function automatic logic [VEC_W-1:0] splat(input logic [EL_W-1:0] v);
        logic [VEC_W-1:0] r;
        for (int k = 0; k < LANES; k++) r[k*EL_W +: EL_W] = v;
        return r;
    endfunction

    function automatic logic [VEC_W-1:0] rand_vec();
        logic [VEC_W-1:0] r;
        for (int k = 0; k < LANES; k++) r[k*EL_W +: EL_W] = EL_W'($urandom);
        return r;
    endfunction

    // Drive one beat for one cycle and queue its expected result.
    task automatic send(input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b,
                        input logic [1:0] op, input bit clr, input string req);
        exp_t   e;
        longint s;
        logic [EL_W-1:0] lg;
        in_valid = 1'b1; in_op = op; in_clear = clr; in_vec_a = a; in_vec_b = b;
        if (op == 2'b01 || op == 2'b10) begin
            lg = (op == 2'b01) ? '1 : '0;
            for (int k = 0; k < LANES; k++)
                lg = (op == 2'b01) ? (lg & a[k*EL_W +: EL_W]) : (lg | a[k*EL_W +: EL_W]);
            e.scalar = SUM_W'(lg);
            model_pend = model_pend | clr;
        end else begin
            s = 0;
            for (int k = 0; k < LANES; k++)
                s += longint'($signed(a[k*EL_W +: EL_W])) * longint'($signed(b[k*EL_W +: EL_W]));
            e.scalar = SUM_W'(s);
            model_acc = (model_pend || clr) ? s : model_acc + s;
            model_pend = 1'b0;
        end
        e.acc = ACC_W'(model_acc);
        e.issue = cyc + 1;
        e.req = req;
        expq.push_back(e);
        @(negedge clk);
        in_valid = 1'b0; in_clear = 1'b0;
    endtask

    task automatic clear_only();
        in_clear = 1'b1; in_valid = 1'b0;
        model_pend = 1'b1;
        @(negedge clk);
        in_clear = 1'b0;
    endtask

    task automatic drain(input string req);
        repeat (LAT + 4) @(negedge clk);
        chk(expq.size() == 0, req, "results outstanding", expq.size(), 0);
    endtask

    // R9: reset state of the outputs.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R9", "valid in reset", out_valid, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(out_valid == 1'b0, "R9", "valid after reset", out_valid, 0);
        chk(out_acc == '0, "R9", "acc after reset", out_acc, 0);
        chk(out_scalar == '0, "R9", "scalar after reset", out_scalar, 0);
    endtask

    // R1 R4 R5: known ascending lanes, then signed lanes accumulated.
    task automatic t_single();
        logic [VEC_W-1:0] a, b;
        for (int k = 0; k < LANES; k++) begin
            a[k*EL_W +: EL_W] = EL_W'(k + 1);
            b[k*EL_W +: EL_W] = EL_W'(k + 1);
        end
        send(a, b, 2'b00, 1'b1, "R1");
        for (int k = 0; k < LANES; k++) begin
            a[k*EL_W +: EL_W] = (k % 2 == 0) ? EL_W'(-300 * (k + 1)) : EL_W'(77 * k);
            b[k*EL_W +: EL_W] = (k % 3 == 0) ? EL_W'(-12345) : EL_W'(999);
        end
        send(a, b, 2'b00, 1'b0, "R4");
        drain("R1");
        chk(out_acc == ACC_W'(model_acc), "R4", "final acc", longint'($signed(out_acc)), model_acc);
    endtask

    // R3: random beats on every cycle.
    task automatic t_stream();
        send(rand_vec(), rand_vec(), 2'b00, 1'b1, "R3");
        for (int i = 0; i < 24; i++) send(rand_vec(), rand_vec(), 2'b00, 1'b0, "R3");
        drain("R3");
    endtask

    // R5: a lone clear pulse and a clear riding on a beat.
    task automatic t_clear();
        for (int i = 0; i < 4; i++) send(rand_vec(), rand_vec(), 2'b00, 1'b0, "R4");
        clear_only();
        repeat (3) @(negedge clk);
        send(rand_vec(), rand_vec(), 2'b00, 1'b0, "R5");
        send(rand_vec(), rand_vec(), 2'b00, 1'b0, "R5");
        send(rand_vec(), rand_vec(), 2'b00, 1'b1, "R5");
        drain("R5");
    endtask

    // R6 R7: logic reductions of A with different B operands.
    task automatic t_logic();
        logic [VEC_W-1:0] a;
        a = rand_vec() | splat(16'h8001);
        send(a, '0, 2'b01, 1'b0, "R6");
        send(a, '1, 2'b01, 1'b0, "R6");
        send(splat(16'hF0F0), rand_vec(), 2'b01, 1'b0, "R6");
        send(a & splat(16'h00FF), '0, 2'b10, 1'b0, "R7");
        send(a & splat(16'h00FF), rand_vec(), 2'b10, 1'b0, "R7");
        send('0, '1, 2'b10, 1'b0, "R7");
        drain("R6");
    endtask

    // R8: logic beats between a clear and a dot beat.
    task automatic t_logic_keep();
        send(rand_vec(), rand_vec(), 2'b00, 1'b0, "R8");
        clear_only();
        send(rand_vec(), rand_vec(), 2'b01, 1'b0, "R8");
        send(rand_vec(), rand_vec(), 2'b10, 1'b0, "R8");
        send(rand_vec(), rand_vec(), 2'b00, 1'b0, "R8");
        send(rand_vec(), rand_vec(), 2'b10, 1'b0, "R8");
        drain("R8");
    endtask

    // R10: worst-case magnitude for 256 beats.
    task automatic t_extreme();
        logic [VEC_W-1:0] m;
        m = splat(16'h8000);
        send(m, m, 2'b00, 1'b1, "R10");
        for (int i = 1; i < 256; i++) send(m, m, 2'b00, 1'b0, "R10");
        drain("R10");
        chk(out_scalar == SUM_W'(64'd1 << 33), "R10", "beat scalar",
            longint'(out_scalar), longint'(64'd1 << 33));
        chk(out_acc == ACC_W'(64'd1 << 41), "R10", "acc 2^41",
            longint'(out_acc), longint'(64'd1 << 41));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        t_reset();
        t_single();
        t_stream();
        t_clear();
        t_logic();
        t_logic_keep();
        t_extreme();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule